// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

The block drives one pulse-width-modulated output from a free-running time base. Each base tick comes from a prescaler that divides the input clock by 1, 4 or 16. Each tick advances a 10-bit count. The upper 8 bits of that count form the period timer, and the lower 2 bits are a sub-count that refines the timer. A period ends when the timer reaches the period setting and the sub-count is full. The count then returns to zero. One period therefore lasts (period + 1) x 4 x prescale input clocks.

The duty value is 10 bits wide. It is supplied as an 8-bit upper part and a 2-bit lower part. The output is high while the count is below the active duty value, so the high time is duty x prescale input clocks. The duty inputs may change at any moment, but the generator works from a shadow copy. That copy is refreshed only at the period boundary, or continuously while the block is disabled, so each period always uses one consistent duty value.

Top module: `pwm10_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `pwm_out` is low.
- R2: While `en` is low, `pwm_out` is low one cycle later, the time base is held at its start, and the shadow duty follows the duty inputs.
- R3: With `en` high, the output pattern repeats every (period + 1) x 4 x prescale input clock cycles.
- R4: Within each period, `pwm_out` is high for the first duty x prescale cycles and low for the rest.
- R5: `psc_sel` selects the prescale: 2'b00 gives 1, 2'b01 gives 4, and 2'b10 or 2'b11 give 16.
- R6: The duty value is {`duty_hi`, `duty_lo`}, with `duty_lo` forming the two least significant bits.
- R7: A duty change made during a period has no effect on that period. It takes effect from the first cycle of the next period.
- R8: A duty value of at least (period + 1) x 4 keeps `pwm_out` high for the whole period.
- R9: A duty value of zero keeps `pwm_out` low for the whole period.
- R10: With a nonzero duty, `pwm_out` is high in the first cycle of every period.
- R11: The cycle after the first clock edge that samples `en` high shows the first cycle of a period, using the duty present while the block was disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the time base at its start |
| period | input | 8 | Period setting of the timer |
| duty_hi | input | 8 | Upper eight bits of the duty value |
| duty_lo | input | 2 | Lower two bits of the duty value |
| psc_sel | input | 2 | Prescale select |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The checker assumes that `period` and `psc_sel` change only while `en` is low. This keeps the count bound, the prescaler range and the forced-high rule for large duty values meaningful. The duty inputs carry no such limit. The stimulus follows this assumption: every configuration is applied with the block disabled for at least one edge, and only then is the block enabled. Random duty writes land at arbitrary cycles within each period, including the last cycle before a boundary.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;

  // Largest prescale expressed as a shift amount (divide by 16).
  localparam int PSC_MAX_SHIFT = 4;

  typedef enum logic [1:0] {
    PSC_DIV1   = 2'b00,
    PSC_DIV4   = 2'b01,
    PSC_DIV16  = 2'b10,
    PSC_DIV16B = 2'b11
  } psc_sel_e;

  // Shift amount of the prescale ratio for a select code.
  function automatic int unsigned psc_shift(input logic [1:0] sel);
    case (psc_sel_e'(sel))
      PSC_DIV1: return 0;
      PSC_DIV4: return 2;
      default:  return 4;
    endcase
  endfunction

endpackage

// File: rtl/pwm10_prescaler.sv
module pwm10_prescaler #(
  parameter int CNT_W = pwm10_pkg::PSC_MAX_SHIFT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [1:0]       sel,
  output logic             tick,
  output logic [CNT_W-1:0] psc_cnt
);

  logic [CNT_W-1:0] term;

  // Last count value before the tick, derived from the prescale ratio.
  always_comb begin
    term = CNT_W'((32'd1 << pwm10_pkg::psc_shift(sel)) - 32'd1);
  end

  assign tick = en && (psc_cnt == term);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      psc_cnt <= '0;
    end else if (tick) begin
      psc_cnt <= '0;
    end else begin
      psc_cnt <= psc_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pwm10_timebase.sv
module pwm10_timebase #(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      tick,
  input  logic [TMR_W-1:0]          period,
  output logic [TMR_W+FRAC_W-1:0]   cnt,
  output logic                      wrap
);

  localparam int CW = TMR_W + FRAC_W;

  logic frac_full;

  // The sub-count may be left out; then every tick advances the timer itself.
  generate
    if (FRAC_W > 0) begin : g_frac
      assign frac_full = &cnt[FRAC_W-1:0];
    end else begin : g_nofrac
      assign frac_full = 1'b1;
    end
  endgenerate

  // Greater-or-equal keeps the timer from running past a lowered period.
  assign wrap = tick && frac_full && (cnt[CW-1:FRAC_W] >= period);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (wrap) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pwm10_duty_shadow.sv
module pwm10_duty_shadow #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          wrap,
  input  logic [DW-1:0] duty_in,
  output logic [DW-1:0] shadow
);

  // Follows the inputs while idle, so the first period uses the setup value.
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
    end else if (!en || wrap) begin
      shadow <= duty_in;
    end
  end

endmodule

// File: rtl/pwm10_compare.sv
module pwm10_compare #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] cnt,
  input  logic [DW-1:0] shadow,
  output logic          pwm_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q <= 1'b0;
    end else begin
      pwm_q <= en && (cnt < shadow);
    end
  end

endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen #(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2,
  parameter int PSC_W  = pwm10_pkg::PSC_MAX_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [TMR_W-1:0]  period,
  input  logic [TMR_W-1:0]  duty_hi,
  input  logic [FRAC_W-1:0] duty_lo,
  input  logic [1:0]        psc_sel,
  output logic              pwm_out
);

  localparam int DW = TMR_W + FRAC_W;

  logic             tick;
  logic [PSC_W-1:0] psc_cnt;
  logic [DW-1:0]    cnt;
  logic             wrap;
  logic [DW-1:0]    duty_in;
  logic [DW-1:0]    shadow;

  assign duty_in = {duty_hi, duty_lo};

  pwm10_prescaler #(.CNT_W(PSC_W)) u_psc (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .sel     (psc_sel),
    .tick    (tick),
    .psc_cnt (psc_cnt)
  );

  pwm10_timebase #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_tb (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .tick   (tick),
    .period (period),
    .cnt    (cnt),
    .wrap   (wrap)
  );

  pwm10_duty_shadow #(.DW(DW)) u_shadow (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .wrap    (wrap),
    .duty_in (duty_in),
    .shadow  (shadow)
  );

  pwm10_compare #(.DW(DW)) u_cmp (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .cnt    (cnt),
    .shadow (shadow),
    .pwm_q  (pwm_out)
  );

endmodule

// File: rtl/pwm10_gen_chk.sv
module pwm10_gen_chk #(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2,
  parameter int PSC_W  = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic [TMR_W-1:0]        period,
  input logic [1:0]              psc_sel,
  input logic                    pwm_out,
  input logic [TMR_W+FRAC_W-1:0] cnt,
  input logic [TMR_W+FRAC_W-1:0] shadow,
  input logic                    wrap,
  input logic [PSC_W-1:0]        psc_cnt
);

  localparam int DW = TMR_W + FRAC_W;

  logic [DW-1:0] cnt_max;
  assign cnt_max = {period, {FRAC_W{1'b1}}};

  // R2: disabled means low output on the next cycle
  p_disabled_low_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_out);

  // R3: the count never runs past the end of the period
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt <= cnt_max));

  // R5: prescaler stays inside the selected ratio
  p_psc_range_r5: assert property (@(posedge clk) disable iff (rst)
    en |-> (32'(psc_cnt) < (32'd1 << pwm10_pkg::psc_shift(psc_sel))));

  // R7: shadow duty only moves on a period boundary while running
  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (en && !wrap) |=> $stable(shadow));

  // R8: duty beyond the period forces a continuous high
  p_big_duty_r8: assert property (@(posedge clk) disable iff (rst)
    (en && (shadow > cnt_max)) |=> pwm_out);

  // R9: zero duty never drives the output high
  p_zero_duty_r9: assert property (@(posedge clk) disable iff (rst)
    (shadow == '0) |=> !pwm_out);

  // R10: start of every period with nonzero duty is high
  p_period_start_r10: assert property (@(posedge clk) disable iff (rst)
    (en && (cnt == '0) && (shadow != '0)) |=> pwm_out);

endmodule

bind pwm10_gen pwm10_gen_chk #(
  .TMR_W (TMR_W),
  .FRAC_W(FRAC_W),
  .PSC_W (PSC_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .period  (period),
  .psc_sel (psc_sel),
  .pwm_out (pwm_out),
  .cnt     (cnt),
  .shadow  (shadow),
  .wrap    (wrap),
  .psc_cnt (psc_cnt)
);

// File: tb/pwm10_gen_bench.sv
`timescale 1ns/1ps
module pwm10_gen_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_d = 1'b0;
  logic [7:0] per_d = 8'd0;
  logic [7:0] hi_d = 8'd0;
  logic [1:0] lo_d = 2'd0;
  logic [1:0] sel_d = 2'd0;
  logic       pwm_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int P = 1;
  int L = 4;
  int act = 0;
  int idx = 0;
  bit just_en = 1'b1;
  bit last_out = 1'b0;

  always #5 clk = ~clk;

  pwm10_gen u_pwm10_gen (
    .clk     (clk),
    .rst     (rst),
    .en      (en_d),
    .period  (per_d),
    .duty_hi (hi_d),
    .duty_lo (lo_d),
    .psc_sel (sel_d),
    .pwm_out (pwm_out)
  );

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 190000", cyc);
      report();
      $finish;
    end
  end

  // Prescale ratio per R5.
  function automatic int ratio(input logic [1:0] s);
    case (s)
      2'b00:   return 1;
      2'b01:   return 4;
      default: return 16;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int actual, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, actual, expv, cyc);
    end
  endtask

  // One clock edge with the expected output computed from the requirements.
  task automatic step();
    int dnow;
    int ph;
    bit expv;
    string tag;
    dnow = int'(hi_d) * 4 + int'(lo_d);      // R6
    if (!en_d) begin
      expv = 1'b0; tag = "R2"; act = dnow; idx = 0; just_en = 1'b1;
    end else begin
      ph = idx % L;
      expv = (ph < act * P);                  // R4
      if (just_en) tag = "R11";
      else if (act == 0) tag = "R9";
      else if (act * P >= L) tag = "R8";
      else if (dnow != act) tag = "R7";
      else if (ph == 0) tag = "R10";
      else tag = "R4";
      if (ph == L - 1) act = dnow;           // R7 boundary reload
      idx++;
      just_en = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    last_out = pwm_out;
    chk(pwm_out === expv, tag, int'(pwm_out), int'(expv));
  endtask

  task automatic set_cfg(input int per, input int sel, input int duty);
    en_d = 1'b0;
    step();
    per_d = 8'(per);
    sel_d = 2'(sel);
    hi_d = 8'(duty >> 2);
    lo_d = 2'(duty);
    P = ratio(sel_d);
    L = (per + 1) * 4 * P;                    // R3
    step();
  endtask

  task automatic run(input int n, input int chg_mod);
    for (int i = 0; i < n; i++) begin
      if (chg_mod > 0 && ($urandom % chg_mod) == 0) begin
        hi_d = 8'($urandom);
        lo_d = 2'($urandom);
      end
      step();
    end
  endtask

  // Measures one full period and its high time.
  task automatic measure(input int per, input int sel, input int hi, input int lo);
    int rises = 0;
    int tcnt = 0;
    int hcnt = 0;
    bit prev = 1'b0;
    set_cfg(per, sel, hi * 4 + lo);
    en_d = 1'b1;
    for (int i = 0; i < 2 * L + 4; i++) begin
      step();
      if (last_out && !prev) rises++;
      if (rises == 1) begin
        tcnt++;
        if (last_out) hcnt++;
      end
      prev = last_out;
    end
    chk(tcnt == L, (sel != 0) ? "R5 period" : "R3 period", tcnt, L);
    chk(hcnt == (hi * 4 + lo) * P, "R6 high time", hcnt, (hi * 4 + lo) * P);
  endtask

  initial begin
    void'($urandom(32'h5eed_0a17));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(pwm_out === 1'b0, "R1 in reset", int'(pwm_out), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(pwm_out === 1'b0, "R1 after reset", int'(pwm_out), 0);
    run(3, 0);

    // R3/R5/R6 measured directly
    measure(9, 0, 3, 2);
    measure(4, 1, 2, 1);
    measure(2, 2, 1, 3);
    measure(1, 3, 0, 1);

    // R9 zero duty, R8 duty at and beyond the period length
    set_cfg(3, 0, 0);  en_d = 1'b1; run(40, 0);
    set_cfg(3, 0, 16); en_d = 1'b1; run(40, 0);
    set_cfg(3, 0, 15); en_d = 1'b1; run(40, 0);
    set_cfg(0, 1, 1023); en_d = 1'b1; run(40, 0);
    set_cfg(0, 0, 1); en_d = 1'b1; run(20, 0);

    // R7 mid-period change, and a change on the last cycle of a period
    set_cfg(9, 0, 10); en_d = 1'b1; run(5, 0);
    hi_d = 8'd7; lo_d = 2'd2; run(50, 0);
    hi_d = 8'd1; lo_d = 2'd0; run(24, 0);
    hi_d = 8'd5; run(60, 0);

    // Full-width period
    set_cfg(255, 0, 700); en_d = 1'b1; run(2100, 0);

    // R2 disable mid-period, then restart (R11)
    set_cfg(7, 1, 20); en_d = 1'b1; run(50, 0);
    en_d = 1'b0; run(4, 0);
    en_d = 1'b1; run(300, 0);

    // Random configurations with random duty writes
    for (int k = 0; k < 20; k++) begin
      set_cfg(int'($urandom % 32), int'($urandom % 4), int'($urandom % 160));
      en_d = 1'b1;
      run(2 * L + 10, 24);
    end

    en_d = 1'b0;
    run(2, 0);
    report();
    $finish;
  end

endmodule